// File: doc/BRIEF.md
# Store-to-Load Forwarding Checker

This block sits next to a small in-order store buffer and decides, for every load presented to it, where that load's data must come from. Stores enter the buffer through an allocate port that returns the slot they took. Their data arrives later through a write port that names that slot. An in-order drain port retires the oldest store. A lookup port takes one load per cycle. Each lookup is answered one cycle later with one of four outcomes: read memory (no overlap), forward (the data comes with the result), wait (the matching store has no data yet), or blocked (the overlap cannot be served from a single store).

Only the youngest buffered store that shares a byte with the load is consulted. Forwarding needs the load to start at exactly that store's address and to be no wider than it. Lookups are independent of each other. A load that is told to wait or is blocked holds nothing up: the requester simply presents it again later, while other loads continue to be answered every cycle.

Top module: `stl_fwd_unit`

## Requirements
- R1: After reset the buffer is empty: `full` is low, `alloc_slot` is 0, `res_valid` is low, and a lookup returns memory.
- R2: A load presented with `ld_valid` high is answered in the next cycle with `res_valid` high; a cycle without a load gives `res_valid` low in the next cycle. A lookup sees the buffer as it was before that cycle's allocate, write or drain.
- R3: `res_kind` is 0 (memory) and `res_data` is 0 when no buffered store shares a byte with the load's range [addr, addr+bytes). Sizes are encoded 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes.
- R4: `res_kind` is 1 (forward) when the youngest overlapping store starts at the load's address, is at least as wide, and has its data written. `res_data` is then the store data's low bytes for the load size, zero-extended to 32 bits.
- R5: `res_kind` is 2 (wait) when the R4 conditions hold except that the store's data has not been written. Once the data is written, the same load forwards.
- R6: `res_kind` is 3 (blocked) when the youngest overlapping store starts at a different address than the load.
- R7: `res_kind` is 3 (blocked) when the load starts at the youngest overlapping store's address but is wider than that store.
- R8: When several buffered stores overlap a load, only the youngest one decides the outcome. A load is answered on its own merits, whatever outcomes the loads just before it received.
- R9: A drain removes the oldest store. A drain on an empty buffer has no effect. After the store that blocked a load drains, the same load sees the next overlapping store or memory.
- R10: `full` is high when all entries hold stores. An allocate while full is dropped, and that store's address afterwards looks up as memory.
- R11: `alloc_slot` gives the slot the next accepted store takes: slots are used in ascending order, wrapping, starting at 0. A data write to a slot that holds no store is ignored, so a store later allocated there reads as wait.
- R12: Addresses are compared on all 32 bits: a store and a load that differ only in bit 31 do not overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alloc_valid | input | 1 | Allocate a store at the youngest position |
| alloc_addr | input | 32 | Store byte address (naturally aligned) |
| alloc_size | input | 2 | Store size code (0=1, 1=2, 2=4 bytes) |
| alloc_slot | output | 2 | Slot the next accepted store occupies |
| full | output | 1 | All slots occupied; allocates are dropped |
| dwr_valid | input | 1 | Write data into a buffered store |
| dwr_slot | input | 2 | Slot to write |
| dwr_data | input | 32 | Store data |
| drain_valid | input | 1 | Retire the oldest store |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | 32 | Load byte address (naturally aligned) |
| ld_size | input | 2 | Load size code (0=1, 1=2, 2=4 bytes) |
| res_valid | output | 1 | Lookup result valid (one cycle after request) |
| res_kind | output | 2 | 0 memory, 1 forward, 2 wait, 3 blocked |
| res_data | output | 32 | Forwarded data, zero-extended; 0 when not forwarding |

## Verification
The bench targets byte and halfword loads at offsets 1 to 3 inside a word store. A design that checked only overlap would forward the wrong bytes there instead of blocking. A wide load over a narrow store at the same address is also probed; a design that compared only start addresses would forward a truncated value. Stacked stores to one address, with the youngest lacking data, expose a design that picks the oldest or the first ready match: it would forward stale data instead of waiting. Drains on an empty buffer, allocates while full, data writes to empty slots and a bit-31 alias each catch a design that corrupts occupancy or compares a truncated address.

// File: rtl/stlf_pkg.sv
package stlf_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    LK_MEMORY  = 2'd0,
    LK_FORWARD = 2'd1,
    LK_WAIT    = 2'd2,
    LK_BLOCKED = 2'd3
  } lk_kind_e;

  function automatic logic [2:0] sz_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] sz_mask(input logic [1:0] code);
    case (code)
      2'd0:    return DATA_W'(32'h0000_00ff);
      2'd1:    return DATA_W'(32'h0000_ffff);
      default: return '1;
    endcase
  endfunction

endpackage

// File: rtl/stlf_buffer.sv
module stlf_buffer
  import stlf_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int DEPTH  = 4,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             alloc_valid,
  input  logic [ADDR_W-1:0]                alloc_addr,
  input  logic [1:0]                       alloc_size,
  input  logic                             dwr_valid,
  input  logic [IDX_W-1:0]                 dwr_slot,
  input  logic [DATA_W-1:0]                dwr_data,
  input  logic                             drain_valid,
  output logic                             full,
  output logic [IDX_W-1:0]                 tail_idx,
  output logic [IDX_W-1:0]                 head_idx,
  output logic [DEPTH-1:0]                 ent_valid,
  output logic [DEPTH-1:0][ADDR_W-1:0]     ent_addr,
  output logic [DEPTH-1:0][1:0]            ent_size,
  output logic [DEPTH-1:0][DATA_W-1:0]     ent_data,
  output logic [DEPTH-1:0]                 ent_dv
);

  logic [IDX_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DEPTH-1:0] valid_q, valid_d;
  logic             alloc_go, drain_go;

  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  always_comb begin
    full     = (cnt_q == CNT_W'(DEPTH));
    alloc_go = alloc_valid && !full;
    drain_go = drain_valid && (cnt_q != '0);
    head_d   = drain_go ? wrap_inc(head_q) : head_q;
    tail_d   = alloc_go ? wrap_inc(tail_q) : tail_q;
    cnt_d    = cnt_q + CNT_W'(alloc_go) - CNT_W'(drain_go);
    valid_d  = valid_q;
    if (drain_go) valid_d[head_q] = 1'b0;
    if (alloc_go) valid_d[tail_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
      valid_q <= '0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      cnt_q   <= cnt_d;
      valid_q <= valid_d;
    end
  end

  assign tail_idx  = tail_q;
  assign head_idx  = head_q;
  assign ent_valid = valid_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic              take, wr;
    logic              dv_q;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        size_q;
    logic [DATA_W-1:0] data_q;

    assign take = alloc_go && (tail_q == IDX_W'(g));
    assign wr   = dwr_valid && valid_q[g] && (dwr_slot == IDX_W'(g)) && !take;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dv_q <= 1'b0;
      else if (take) dv_q <= 1'b0;
      else if (wr)   dv_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (take) begin
        addr_q <= alloc_addr;
        size_q <= alloc_size;
      end
      if (wr) data_q <= dwr_data;
    end

    assign ent_addr[g] = addr_q;
    assign ent_size[g] = size_q;
    assign ent_data[g] = data_q;
    assign ent_dv[g]   = dv_q;
  end

  // R10: occupancy never exceeds the buffer depth
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R10: per-slot valid bits agree with the occupancy counter
  a_r10_valid_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(valid_q) == int'(cnt_q));

  // R10: an allocate on a full buffer without a drain leaves occupancy alone
  a_r10_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (full && alloc_valid && !drain_valid) |=> $stable(cnt_q));

  // R9: draining an empty buffer keeps it empty
  a_r9_empty_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && drain_valid && !alloc_valid) |=> (cnt_q == '0 && valid_q == '0));

endmodule

// File: rtl/stlf_match.sv
module stlf_match
  import stlf_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int DEPTH  = 4,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            ld_addr,
  input  logic [1:0]                   ld_size,
  input  logic [IDX_W-1:0]             head_idx,
  input  logic [DEPTH-1:0]             ent_valid,
  input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
  input  logic [DEPTH-1:0][1:0]        ent_size,
  input  logic [DEPTH-1:0][DATA_W-1:0] ent_data,
  input  logic [DEPTH-1:0]             ent_dv,
  output lk_kind_e                     kind,
  output logic [DATA_W-1:0]            fwd_data
);

  localparam int EXT_W = ADDR_W + 1;

  logic [DEPTH-1:0]  ovl;
  logic [DEPTH-1:0]  sel_oh;
  logic [ADDR_W-1:0] sel_addr;
  logic [1:0]        sel_size;
  logic [DATA_W-1:0] sel_data;
  logic              sel_dv;
  logic [EXT_W-1:0]  ld_lo, ld_hi;

  function automatic logic [IDX_W-1:0] age_slot(input logic [IDX_W-1:0] h, input int k);
    int s;
    s = int'(h) + k;
    if (s >= DEPTH) s = s - DEPTH;
    return IDX_W'(s);
  endfunction

  assign ld_lo = {1'b0, ld_addr};
  assign ld_hi = ld_lo + EXT_W'(sz_bytes(ld_size));

  for (genvar g = 0; g < DEPTH; g++) begin : g_ovl
    logic [EXT_W-1:0] st_lo, st_hi;
    assign st_lo  = {1'b0, ent_addr[g]};
    assign st_hi  = st_lo + EXT_W'(sz_bytes(ent_size[g]));
    assign ovl[g] = ent_valid[g] && (ld_lo < st_hi) && (st_lo < ld_hi);
  end

  always_comb begin
    sel_oh = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (ovl[age_slot(head_idx, k)]) begin
        sel_oh = '0;
        sel_oh[age_slot(head_idx, k)] = 1'b1;
      end
    end
    sel_addr = '0;
    sel_size = '0;
    sel_data = '0;
    sel_dv   = 1'b0;
    for (int g = 0; g < DEPTH; g++) begin
      if (sel_oh[g]) begin
        sel_addr = sel_addr | ent_addr[g];
        sel_size = sel_size | ent_size[g];
        sel_data = sel_data | ent_data[g];
        sel_dv   = sel_dv | ent_dv[g];
      end
    end
  end

  always_comb begin
    fwd_data = '0;
    if (sel_oh == '0) begin
      kind = LK_MEMORY;
    end else if (sel_addr != ld_addr || sz_bytes(ld_size) > sz_bytes(sel_size)) begin
      kind = LK_BLOCKED;
    end else if (!sel_dv) begin
      kind = LK_WAIT;
    end else begin
      kind     = LK_FORWARD;
      fwd_data = sel_data & sz_mask(ld_size);
    end
  end

  // R8: at most one store is chosen to decide a load
  a_r8_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_oh));

  // R3: memory is reported exactly when no valid store overlaps
  a_r3_memory_iff_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == LK_MEMORY) == (ovl == '0));

endmodule

// File: rtl/stl_fwd_unit.sv
module stl_fwd_unit
  import stlf_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int DEPTH  = 4,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [1:0]        alloc_size,
  output logic [IDX_W-1:0]  alloc_slot,
  output logic              full,
  input  logic              dwr_valid,
  input  logic [IDX_W-1:0]  dwr_slot,
  input  logic [DATA_W-1:0] dwr_data,
  input  logic              drain_valid,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [1:0]        ld_size,
  output logic              res_valid,
  output logic [1:0]        res_kind,
  output logic [DATA_W-1:0] res_data
);

  logic [1:0]                   rst_sync_q;
  logic                         rst_int_n;
  logic [IDX_W-1:0]             head_idx;
  logic [DEPTH-1:0]             ent_valid;
  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
  logic [DEPTH-1:0][1:0]        ent_size;
  logic [DEPTH-1:0][DATA_W-1:0] ent_data;
  logic [DEPTH-1:0]             ent_dv;
  lk_kind_e                     kind_c;
  logic [DATA_W-1:0]            data_c;
  logic                         res_valid_q;
  lk_kind_e                     res_kind_q;
  logic [DATA_W-1:0]            res_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  stlf_buffer #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_buf (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .alloc_valid (alloc_valid),
    .alloc_addr  (alloc_addr),
    .alloc_size  (alloc_size),
    .dwr_valid   (dwr_valid),
    .dwr_slot    (dwr_slot),
    .dwr_data    (dwr_data),
    .drain_valid (drain_valid),
    .full        (full),
    .tail_idx    (alloc_slot),
    .head_idx    (head_idx),
    .ent_valid   (ent_valid),
    .ent_addr    (ent_addr),
    .ent_size    (ent_size),
    .ent_data    (ent_data),
    .ent_dv      (ent_dv)
  );

  stlf_match #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_match (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ld_addr   (ld_addr),
    .ld_size   (ld_size),
    .head_idx  (head_idx),
    .ent_valid (ent_valid),
    .ent_addr  (ent_addr),
    .ent_size  (ent_size),
    .ent_data  (ent_data),
    .ent_dv    (ent_dv),
    .kind      (kind_c),
    .fwd_data  (data_c)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_valid_q <= 1'b0;
      res_kind_q  <= LK_MEMORY;
      res_data_q  <= '0;
    end else begin
      res_valid_q <= ld_valid;
      if (ld_valid) begin
        res_kind_q <= kind_c;
        res_data_q <= data_c;
      end
    end
  end

  assign res_valid = res_valid_q;
  assign res_kind  = res_kind_q;
  assign res_data  = res_data_q;

  // R2: every load is answered on the following cycle
  a_r2_answer_next: assert property (@(posedge clk) disable iff (!rst_int_n)
    ld_valid |=> res_valid);

  // R2: no answer appears without a request
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ld_valid |=> !res_valid);

  // R4: a forwarded byte load carries zeros above its low byte
  a_r4_byte_zext: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ld_valid && ld_size == 2'd0) |=> (res_kind != 2'd1 || res_data[31:8] == '0));

  // R3: outcomes other than forward carry no data
  a_r3_zero_data: assert property (@(posedge clk) disable iff (!rst_int_n)
    ld_valid |=> (res_kind == 2'd1 || res_data == '0));

endmodule

// File: tb/sim_stl_fwd_unit.sv
`timescale 1ns/1ps
module sim_stl_fwd_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        alloc_valid;
  logic [31:0] alloc_addr;
  logic [1:0]  alloc_size;
  logic [1:0]  alloc_slot;
  logic        full;
  logic        dwr_valid;
  logic [1:0]  dwr_slot;
  logic [31:0] dwr_data;
  logic        drain_valid;
  logic        ld_valid;
  logic [31:0] ld_addr;
  logic [1:0]  ld_size;
  logic        res_valid;
  logic [1:0]  res_kind;
  logic [31:0] res_data;

  always #2.5 clk = ~clk;

  stl_fwd_unit u0 (.*);

  int checks   = 0;
  int failures = 0;

  // reference model of the buffer
  logic [31:0] m_addr [4];
  logic [1:0]  m_size [4];
  logic [31:0] m_data [4];
  logic        m_dv   [4];
  logic        m_valid[4];
  int          m_head, m_cnt;

  // pending expectation for the lookup made in the previous cycle
  bit          e_valid;
  logic [1:0]  e_kind;
  logic [31:0] e_data;
  string       e_tag;

  localparam logic [1:0] K_MEM = 2'd0, K_FWD = 2'd1, K_WAIT = 2'd2, K_BLK = 2'd3;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] lowmask(input logic [1:0] c);
    return (c == 2'd0) ? 32'hff : (c == 2'd1) ? 32'hffff : 32'hffff_ffff;
  endfunction

  task automatic predict(input logic [31:0] la, input logic [1:0] ls,
                         output logic [1:0] kind, output logic [31:0] data);
    int     sel;
    longint l0, l1, s0, s1;
    sel = -1;
    l0 = longint'({32'h0, la});
    l1 = l0 + nbytes(ls);
    for (int k = 0; k < m_cnt; k++) begin
      int s;
      s  = (m_head + k) % 4;
      s0 = longint'({32'h0, m_addr[s]});
      s1 = s0 + nbytes(m_size[s]);
      if (l0 < s1 && s0 < l1) sel = s;
    end
    data = 32'h0;
    if (sel < 0) kind = K_MEM;
    else if (m_addr[sel] != la || nbytes(ls) > nbytes(m_size[sel])) kind = K_BLK;
    else if (!m_dv[sel]) kind = K_WAIT;
    else begin
      kind = K_FWD;
      data = m_data[sel] & lowmask(ls);
    end
  endtask

  task automatic step(input bit av, input logic [31:0] aa, input logic [1:0] as_,
                      input bit wv, input logic [1:0] ws, input logic [31:0] wd,
                      input bit dv, input bit lv, input logic [31:0] la,
                      input logic [1:0] ls, input string tag);
    int  tail;
    bit  was_full;
    // outputs from the previous edge
    chk(res_valid == e_valid, "R2", "res_valid", 32'(res_valid), 32'(e_valid));
    if (e_valid) begin
      chk(res_kind == e_kind, e_tag, "res_kind", 32'(res_kind), 32'(e_kind));
      chk(res_data == e_data, e_tag, "res_data", res_data, e_data);
    end
    chk(full == (m_cnt == 4), "R10", "full", 32'(full), 32'(m_cnt == 4));
    chk(alloc_slot == 2'((m_head + m_cnt) % 4), "R11", "alloc_slot",
        32'(alloc_slot), 32'((m_head + m_cnt) % 4));
    // drive
    alloc_valid = av; alloc_addr = aa; alloc_size = as_;
    dwr_valid = wv;   dwr_slot = ws;   dwr_data = wd;
    drain_valid = dv;
    ld_valid = lv;    ld_addr = la;    ld_size = ls;
    // expectation from the pre-edge state
    e_valid = lv;
    if (lv) begin
      predict(la, ls, e_kind, e_data);
      if (tag != "") e_tag = tag;
      else e_tag = (e_kind == K_MEM) ? "R3" : (e_kind == K_FWD) ? "R4" :
                   (e_kind == K_WAIT) ? "R5" : "R6";
    end
    // model update
    tail     = (m_head + m_cnt) % 4;
    was_full = (m_cnt == 4);
    if (wv && m_valid[ws]) begin
      m_data[ws] = wd;
      m_dv[ws]   = 1'b1;
    end
    if (dv && m_cnt > 0) begin
      m_valid[m_head] = 1'b0;
      m_head = (m_head + 1) % 4;
      m_cnt--;
    end
    if (av && !was_full) begin
      m_valid[tail] = 1'b1;
      m_addr[tail]  = aa;
      m_size[tail]  = as_;
      m_dv[tail]    = 1'b0;
      m_cnt++;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask
  task automatic alloc(input logic [31:0] a, input logic [1:0] s);
    step(1, a, s, 0, 0, 0, 0, 0, 0, 0, "");
  endtask
  task automatic wdata(input logic [1:0] slot, input logic [31:0] d);
    step(0, 0, 0, 1, slot, d, 0, 0, 0, 0, "");
  endtask
  task automatic drain();
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "");
  endtask
  task automatic look(input logic [31:0] a, input logic [1:0] s, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 1, a, s, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst_n = 1'b0;
    alloc_valid = 0; alloc_addr = 0; alloc_size = 0;
    dwr_valid = 0; dwr_slot = 0; dwr_data = 0; drain_valid = 0;
    ld_valid = 0; ld_addr = 0; ld_size = 0;
    for (int i = 0; i < 4; i++) begin
      m_valid[i] = 0; m_dv[i] = 0; m_addr[i] = 0; m_size[i] = 0; m_data[i] = 0;
    end
    m_head = 0; m_cnt = 0;
    e_valid = 0; e_kind = 0; e_data = 0; e_tag = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk(full == 1'b0, "R1", "full", 32'(full), 0);
    chk(alloc_slot == 2'd0, "R1", "alloc_slot", 32'(alloc_slot), 0);
    chk(res_valid == 1'b0, "R1", "res_valid", 32'(res_valid), 0);
    look(32'h100, 2'd2, "R1");

    // R5 then R4: word store, data written during the first lookup
    alloc(32'h100, 2'd2);
    step(0, 0, 0, 1, 2'd0, 32'h4433_2211, 0, 1, 32'h100, 2'd0, "R5");
    look(32'h100, 2'd0, "R4");
    look(32'h100, 2'd1, "R4");
    look(32'h100, 2'd2, "R4");
    // R6: non-zero offsets inside the word
    look(32'h101, 2'd0, "R6");
    look(32'h102, 2'd0, "R6");
    look(32'h103, 2'd0, "R6");
    look(32'h102, 2'd1, "R6");
    // R8: a forwarding load right after a blocked one
    look(32'h100, 2'd0, "R8");
    // R3 / R12: no overlap, bit-31 alias
    look(32'h200, 2'd2, "R3");
    look(32'h8000_0100, 2'd2, "R12");

    // R7: wide load over a narrower store at the same address
    alloc(32'h300, 2'd1);
    wdata(2'd1, 32'h0000_beef);
    look(32'h300, 2'd2, "R7");
    look(32'h300, 2'd1, "R4");

    // R8: youngest overlapping store decides
    alloc(32'h400, 2'd2);
    wdata(2'd2, 32'hcafe_f00d);
    look(32'h400, 2'd0, "R4");
    alloc(32'h400, 2'd0);
    look(32'h400, 2'd0, "R8");
    look(32'h400, 2'd1, "R8");
    // R10: full, allocate dropped
    alloc(32'h500, 2'd2);
    look(32'h500, 2'd2, "R10");
    wdata(2'd3, 32'h0000_0077);
    look(32'h400, 2'd0, "R8");

    // R9: drains in order
    drain();
    look(32'h101, 2'd0, "R9");
    look(32'h300, 2'd2, "R7");
    drain();
    look(32'h300, 2'd2, "R9");
    drain();
    look(32'h400, 2'd2, "R7");
    drain();
    look(32'h400, 2'd2, "R9");
    drain();
    idle();

    // R11: data write to an empty slot ignored
    wdata(2'd0, 32'h1111_1111);
    alloc(32'h600, 2'd2);
    look(32'h600, 2'd2, "R11");
    drain();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      bit          av, wv, dv, lv;
      logic [1:0]  as_, ls;
      logic [31:0] aa, la;
      as_ = 2'($urandom % 3);
      ls  = 2'($urandom % 3);
      aa  = 32'h1000 | (32'($urandom % 16) & ~32'(nbytes(as_) - 1));
      la  = 32'h1000 | (32'($urandom % 16) & ~32'(nbytes(ls) - 1));
      if ($urandom % 16 == 0) la = la | 32'h8000_0000;
      av = ($urandom % 10) < 3;
      wv = ($urandom % 10) < 3;
      dv = ($urandom % 10) < 2;
      lv = ($urandom % 20) < 17;
      step(av, aa, as_, wv, 2'($urandom % 4), $urandom, dv, lv, la, ls, "");
    end
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule